// File: doc/BRIEF.md
# UART FIFO Watermark Interrupt Controller

This block stores the byte queues of a serial port in both directions and decides when the port should ask software for service. The receive shift engine pushes each incoming character into it, together with that character's framing and parity error flags. The transmit shift engine pops outgoing characters from it. Software reaches both queues and all settings through a small register bus with single-cycle reads and writes.

Service requests come from four sources. The first is a receive watermark, asserted when enough bytes are waiting. The second is a transmit watermark, asserted when few enough bytes remain queued. The third is an idle timer that flags a partly filled receive queue after it has gone quiet for a set number of character periods. The fourth is a latched break indication. Each source has its own enable bit. The enabled sources are ORed into one registered interrupt line. The surrounding logic provides a one-cycle `char_tick` pulse once per character period.

Top module: `uart_fifo_irq`

Register map (`bus_addr`): 0 receive data (read pops), 1 transmit data (write pushes), 2 thresholds, 3 interrupt enables, 4 status (write 1 to clear), 5 fill levels.

## Requirements
- R1: Each queue holds 32 entries and delivers them in arrival order. A read of address 0 returns the oldest received character in bits 7:0, its frame-error flag in bit 8 and its parity-error flag in bit 9, and removes that entry. Address 5 returns the receive fill level in bits 5:0 and the transmit fill level in bits 13:8.
- R2: Status bit 4 (receive-ready) is 1 exactly when the receive fill level is at least the effective receive threshold. The raw threshold is address 2, bits 5:0.
- R3: Status bit 5 (transmit-ready) is 1 exactly when the transmit fill level is no more than the effective transmit threshold. The raw threshold is address 2, bits 13:8. This threshold counts bytes still queued, not free slots.
- R4: A raw threshold of 0 acts as 1, and any raw threshold above 32 acts as 32. Address 2 reads back the raw values.
- R5: Status bit 6 (data-ready) is 1 exactly when the receive queue holds at least one byte.
- R6: Status bit 0 (aging) is set on the 8th character tick counted while the receive queue is non-empty. An accepted receive push or a receive-data read in the same cycle as a tick stops that tick from counting, and either one restarts the count. The count stays at zero while the queue is empty, and the flag is set only once per quiet period.
- R7: Status bits 3:0 are sticky and are cleared by writing 1 to them at address 4, so writing all ones clears them all. If a bit is set and cleared in the same cycle, the set wins.
- R8: A write to address 1 while the transmit queue is full and not being popped is dropped, and it sets status bit 2 (transmit overflow). A write in the same cycle as a pop of a full queue is accepted.
- R9: A receive push while the receive queue is full and not being read is dropped, and it sets status bit 3 (receive overrun). A push in the same cycle as a read of a full queue is accepted.
- R10: A `brk_det` pulse sets status bit 1 (break), and the bit stays set until it is cleared.
- R11: The enables at address 3 are bit 0 receive-ready, bit 1 aging, bit 2 transmit-ready and bit 3 break. `irq` equals, one clock later, the OR of each source ANDed with its enable.
- R12: After reset both queues are empty, the thresholds are 24 (receive) and 8 (transmit), all enables and sticky flags are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at address 0) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| rx_push | input | 1 | Receiver delivers a character |
| rx_byte | input | 8 | Received character |
| rx_ferr | input | 1 | Frame error flag of the character |
| rx_perr | input | 1 | Parity error flag of the character |
| brk_det | input | 1 | Break-condition pulse |
| char_tick | input | 1 | One pulse per character period |
| tx_pop | input | 1 | Transmitter takes the head byte |
| tx_byte | output | 8 | Head byte of the transmit queue |
| tx_avail | output | 1 | Transmit queue is not empty |
| irq | output | 1 | Registered combined interrupt |

## Verification
The collision that matters is a queue being filled and drained in the same cycle while it is completely full. On the receive side, the bench raises `rx_push` and a data read on the same edge with 32 bytes stored. On the transmit side, a bus write lands in the cycle where the draining monitor first pops a full queue. Both cases are judged on three points: the fill level stays at 32, the overflow or overrun flag stays clear, and the scoreboard queue gets the new byte in order behind the ones already stored. A set and a write-1 clear of the break flag in the same cycle are also provoked, and the flag is expected to stay set.

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq #(
  parameter int DEPTH      = 32,
  parameter int THR_W      = 6,
  parameter int AGE_TICKS  = 8,
  parameter int RX_THR_RST = 24,
  parameter int TX_THR_RST = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        rx_ferr,
  input  logic        rx_perr,
  input  logic        brk_det,
  input  logic        char_tick,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  output logic        tx_avail,
  output logic        irq
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int AGW = $clog2(AGE_TICKS + 1);
  localparam logic [2:0] A_RXD = 3'd0;
  localparam logic [2:0] A_TXD = 3'd1;
  localparam logic [2:0] A_THR = 3'd2;
  localparam logic [2:0] A_EN  = 3'd3;
  localparam logic [2:0] A_STS = 3'd4;
  localparam logic [2:0] A_LVL = 3'd5;

  logic [9:0]       rx_mem [DEPTH];
  logic [7:0]       tx_mem [DEPTH];
  logic [AW-1:0]    rx_wp, rx_rp, tx_wp, tx_rp;
  logic [CW-1:0]    rx_cnt, tx_cnt;
  logic [THR_W-1:0] rx_thr, tx_thr;
  logic [3:0]       en, sts;
  logic [AGW-1:0]   age;

  function automatic logic [CW-1:0] clamp(input logic [THR_W-1:0] v);
    if (v == '0)              return CW'(1);
    else if (int'(v) > DEPTH) return CW'(DEPTH);
    else                      return CW'(v);
  endfunction

  logic rx_pop, rx_acc, tx_pop_ok, tx_acc, wr_tx, age_hit;
  logic rxrdy, txrdy, dready, pend;
  logic [3:0] sts_set, sts_clr;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign wr_tx     = bus_wr && bus_addr == A_TXD;
  assign rx_pop    = bus_rd && bus_addr == A_RXD && rx_cnt != '0;
  assign rx_acc    = rx_push && (rx_cnt != CW'(DEPTH) || rx_pop);
  assign tx_pop_ok = tx_pop && tx_cnt != '0;
  assign tx_acc    = wr_tx && (tx_cnt != CW'(DEPTH) || tx_pop_ok);

  assign rxrdy  = rx_cnt >= clamp(rx_thr);
  assign txrdy  = tx_cnt <= clamp(tx_thr);
  assign dready = rx_cnt != '0;

  assign age_hit = char_tick && !rx_acc && !rx_pop && rx_cnt != '0 &&
                   age == AGW'(AGE_TICKS - 1);
  assign sts_set = {rx_push && !rx_acc, wr_tx && !tx_acc, brk_det, age_hit};
  assign sts_clr = (bus_wr && bus_addr == A_STS) ? bus_wdata[3:0] : 4'd0;
  assign pend    = |(en & {sts[1], txrdy, sts[0], rxrdy});

  assign tx_byte  = tx_mem[tx_rp];
  assign tx_avail = tx_cnt != '0;

  always_ff @(posedge clk) begin
    if (rx_acc) rx_mem[rx_wp] <= {rx_perr, rx_ferr, rx_byte};
    if (tx_acc) tx_mem[tx_wp] <= bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      tx_wp  <= '0;
      tx_rp  <= '0;
      rx_cnt <= '0;
      tx_cnt <= '0;
      rx_thr <= THR_W'(RX_THR_RST);
      tx_thr <= THR_W'(TX_THR_RST);
      en     <= '0;
      sts    <= '0;
      age    <= '0;
      irq    <= 1'b0;
    end else begin
      if (rx_acc)    rx_wp <= rx_wp + AW'(1);
      if (rx_pop)    rx_rp <= rx_rp + AW'(1);
      if (tx_acc)    tx_wp <= tx_wp + AW'(1);
      if (tx_pop_ok) tx_rp <= tx_rp + AW'(1);
      rx_cnt <= rx_cnt + CW'(rx_acc) - CW'(rx_pop);
      tx_cnt <= tx_cnt + CW'(tx_acc) - CW'(tx_pop_ok);
      if (bus_wr && bus_addr == A_THR) begin
        rx_thr <= bus_wdata[THR_W-1:0];
        tx_thr <= bus_wdata[8 +: THR_W];
      end
      if (bus_wr && bus_addr == A_EN) en <= bus_wdata[3:0];
      sts <= (sts & ~sts_clr) | sts_set;
      if (rx_acc || rx_pop || rx_cnt == '0)
        age <= '0;
      else if (char_tick && age != AGW'(AGE_TICKS))
        age <= age + AGW'(1);
      irq <= pend;
    end
  end

  always_comb begin
    case (bus_addr)
      A_RXD:   bus_rdata = dready ? 16'(rx_mem[rx_rp]) : 16'd0;
      A_THR:   bus_rdata = 16'(rx_thr) | (16'(tx_thr) << 8);
      A_EN:    bus_rdata = 16'(en);
      A_STS:   bus_rdata = 16'({dready, txrdy, rxrdy, sts});
      A_LVL:   bus_rdata = 16'(rx_cnt) | (16'(tx_cnt) << 8);
      default: bus_rdata = 16'd0;
    endcase
  end
endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 6,
  parameter int AGW   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [2:0]    bus_addr,
  input logic [15:0]   bus_wdata,
  input logic          rx_push,
  input logic          tx_pop,
  input logic          brk_det,
  input logic          irq,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic [AGW-1:0] age,
  input logic [3:0]    en,
  input logic [3:0]    sts
);
  AST_RX_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rx_cnt) <= DEPTH); // R1
  AST_TX_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_cnt) <= DEPTH); // R1
  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1 && int'(tx_cnt) == DEPTH && !tx_pop)
    |=> (int'(tx_cnt) == DEPTH && sts[2])); // R8
  AST_RX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && int'(rx_cnt) == DEPTH && !(bus_rd && bus_addr == 3'd0))
    |=> (int'(rx_cnt) == DEPTH && sts[3])); // R9
  AST_AGE_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0) |-> (age == '0)); // R6
  AST_BRK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |=> sts[1]); // R10
  AST_BRK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4 && bus_wdata[1] && !brk_det) |=> !sts[1]); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(en != 4'd0)); // R11
endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(.DEPTH(DEPTH), .CW(CW), .AGW(AGW)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_push(rx_push),
  .tx_pop(tx_pop), .brk_det(brk_det), .irq(irq), .rx_cnt(rx_cnt),
  .tx_cnt(tx_cnt), .age(age), .en(en), .sts(sts)
);

// File: tb/test_uart_fifo_irq.sv
module test_uart_fifo_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        rx_push = 1'b0, rx_ferr = 1'b0, rx_perr = 1'b0;
  logic [7:0]  rx_byte = 8'd0;
  logic        brk_det = 1'b0, char_tick = 1'b0, tx_pop = 1'b0;
  logic [7:0]  tx_byte;
  logic        tx_avail, irq;

  int checks = 0, fails = 0;
  int rx_n = 0, tx_n = 0;
  logic drain_en = 1'b0;
  logic [15:0] rxq[$];
  logic [7:0]  txq[$];
  logic [15:0] d;

  uart_fifo_irq i_uart_fifo_irq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
    .brk_det(brk_det), .char_tick(char_tick), .tx_pop(tx_pop),
    .tx_byte(tx_byte), .tx_avail(tx_avail), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); bus_addr = a; #2; v = bus_rdata;
  endtask

  task automatic sts_bit(input string req, input int b, input logic e);
    logic [15:0] s;
    peek(3'd4, s);
    chk(req, 32'(s[b]), 32'(e));
  endtask

  // driver: receiver side
  task automatic rxpush(input logic [7:0] b, input logic f, input logic p);
    @(negedge clk); rx_push = 1'b1; rx_byte = b; rx_ferr = f; rx_perr = p;
    if (rx_n < 32) begin rxq.push_back({6'd0, p, f, b}); rx_n++; end
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic rxread(input string req);
    logic [15:0] e;
    @(negedge clk); bus_addr = 3'd0; bus_rd = 1'b1; #2;
    e = rxq.pop_front(); rx_n--;
    chk(req, 32'(bus_rdata), 32'(e));
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rxdrain(input string req);
    while (rx_n > 0) rxread(req);
  endtask

  task automatic txw(input logic [7:0] b);
    wr(3'd1, 16'(b));
    if (tx_n < 32) begin txq.push_back(b); tx_n++; end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk); char_tick = 1'b1;
      @(negedge clk); char_tick = 1'b0;
    end
  endtask

  // monitor: transmitter side pops and compares against the scoreboard
  always begin
    @(negedge clk); #1;
    if (drain_en && tx_avail) begin
      if (txq.size() == 0) chk("R1 tx order", 32'(tx_byte), 32'hdead);
      else chk("R1 tx order", 32'(tx_byte), 32'(txq.pop_front()));
      tx_pop = 1'b1;
    end else tx_pop = 1'b0;
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    peek(3'd4, d); chk("R12 status", 32'(d), 32'h20);
    peek(3'd2, d); chk("R12 thresholds", 32'(d), 32'h0818);
    peek(3'd3, d); chk("R12 enables", 32'(d), 0);
    peek(3'd5, d); chk("R12 levels", 32'(d), 0);
    chk("R12 irq", 32'(irq), 0);
    chk("R12 tx_avail", 32'(tx_avail), 0);

    // R1 / R5 basic receive path with flags
    rxpush(8'h41, 1'b1, 1'b0);
    rxpush(8'h5a, 1'b0, 1'b1);
    rxpush(8'hc3, 1'b1, 1'b1);
    sts_bit("R5 data-ready set", 6, 1'b1);
    sts_bit("R2 below threshold", 4, 1'b0);
    rxdrain("R1 rx word");
    sts_bit("R5 data-ready clear", 6, 1'b0);

    // R2 receive watermark at 4
    wr(3'd2, 16'h0804);
    for (int i = 0; i < 3; i++) rxpush(8'(i + 16), 1'b0, 1'b0);
    sts_bit("R2 three below four", 4, 1'b0);
    rxpush(8'h77, 1'b0, 1'b0);
    sts_bit("R2 four reaches four", 4, 1'b1);
    rxdrain("R1 rx word");
    sts_bit("R2 empty", 4, 1'b0);

    // R4 clamp of zero to one
    wr(3'd2, 16'h0800);
    sts_bit("R4 zero clamp empty", 4, 1'b0);
    rxpush(8'h12, 1'b0, 1'b0);
    sts_bit("R4 zero clamp one byte", 4, 1'b1);
    rxdrain("R1 rx word");

    // R4 clamp above 32, R9 overrun, R7 clear, concurrent push+read
    wr(3'd2, 16'h0828);
    for (int i = 0; i < 31; i++) rxpush(8'(i * 7), i[0], i[1]);
    sts_bit("R4 high clamp at 31", 4, 1'b0);
    rxpush(8'hee, 1'b0, 1'b1);
    sts_bit("R4 high clamp at 32", 4, 1'b1);
    rxpush(8'h99, 1'b1, 1'b1);
    sts_bit("R9 overrun flag", 3, 1'b1);
    peek(3'd5, d); chk("R9 level held", 32'(d[5:0]), 32);
    wr(3'd4, 16'h0008);
    sts_bit("R7 overrun cleared", 3, 1'b0);
    @(negedge clk);
    bus_addr = 3'd0; bus_rd = 1'b1; rx_push = 1'b1; rx_byte = 8'h3c;
    rx_ferr = 1'b0; rx_perr = 1'b0; #2;
    chk("R9 read while full", 32'(bus_rdata), 32'(rxq.pop_front()));
    rxq.push_back(16'h003c);
    @(negedge clk); bus_rd = 1'b0; rx_push = 1'b0;
    peek(3'd5, d); chk("R9 simultaneous level", 32'(d[5:0]), 32);
    sts_bit("R9 no overrun when read", 3, 1'b0);
    rxdrain("R1 rx order");
    wr(3'd2, 16'h0818);

    // R3 transmit watermark counts queued bytes
    for (int i = 0; i < 8; i++) txw(8'(i + 8'h80));
    sts_bit("R3 eight queued", 5, 1'b1);
    txw(8'h88);
    sts_bit("R3 nine queued", 5, 1'b0);
    wr(3'd2, 16'h3f18);
    sts_bit("R4 tx high clamp", 5, 1'b1);
    for (int i = 9; i < 32; i++) txw(8'(i + 8'h80));
    peek(3'd5, d); chk("R1 tx full level", 32'(d[13:8]), 32);
    sts_bit("R4 tx clamp at full", 5, 1'b1);
    txw(8'h55);
    sts_bit("R8 overflow flag", 2, 1'b1);
    peek(3'd5, d); chk("R8 level held", 32'(d[13:8]), 32);
    wr(3'd4, 16'h0004);
    sts_bit("R7 overflow cleared", 2, 1'b0);
    @(negedge clk);
    drain_en = 1'b1; bus_addr = 3'd1; bus_wdata = 16'h00a5; bus_wr = 1'b1;
    txq.push_back(8'ha5);
    @(negedge clk); bus_wr = 1'b0;
    sts_bit("R8 write with pop accepted", 2, 1'b0);
    while (tx_avail) @(negedge clk);
    repeat (2) @(negedge clk);
    drain_en = 1'b0; tx_n = 0;
    chk("R8 all bytes emitted", 32'(txq.size()), 0);
    wr(3'd2, 16'h0818);

    // R6 aging
    rxpush(8'h01, 1'b0, 1'b0);
    tick(7);
    sts_bit("R6 seven ticks", 0, 1'b0);
    rxpush(8'h02, 1'b0, 1'b0);
    tick(7);
    sts_bit("R6 push restarts", 0, 1'b0);
    tick(1);
    sts_bit("R6 eighth tick", 0, 1'b1);
    wr(3'd4, 16'h0001);
    tick(3);
    sts_bit("R6 once per quiet period", 0, 1'b0);
    rxdrain("R1 rx word");
    tick(10);
    sts_bit("R6 empty never ages", 0, 1'b0);
    rxpush(8'h03, 1'b0, 1'b0);
    rxpush(8'h04, 1'b0, 1'b0);
    tick(5);
    rxread("R1 rx word");
    tick(7);
    sts_bit("R6 read restarts", 0, 1'b0);
    tick(1);
    sts_bit("R6 eighth after read", 0, 1'b1);
    rxdrain("R1 rx word");
    wr(3'd4, 16'hffff);
    sts_bit("R7 all ones clears aging", 0, 1'b0);

    // R10 break, R7 set wins over clear
    @(negedge clk); brk_det = 1'b1;
    @(negedge clk); brk_det = 1'b0;
    sts_bit("R10 break latched", 1, 1'b0 | 1'b1);
    @(negedge clk); brk_det = 1'b1; bus_addr = 3'd4; bus_wdata = 16'h0002; bus_wr = 1'b1;
    @(negedge clk); brk_det = 1'b0; bus_wr = 1'b0;
    sts_bit("R7 set wins", 1, 1'b1);

    // R11 interrupt gating and latency
    chk("R11 no enable no irq", 32'(irq), 0);
    wr(3'd3, 16'h0008);
    chk("R11 latency", 32'(irq), 0);
    @(negedge clk);
    chk("R11 break irq", 32'(irq), 1);
    wr(3'd4, 16'h0002);
    chk("R11 irq lags clear", 32'(irq), 1);
    @(negedge clk);
    chk("R11 irq drops", 32'(irq), 0);
    wr(3'd3, 16'h0004);
    @(negedge clk);
    chk("R11 tx-ready irq", 32'(irq), 1);
    wr(3'd3, 16'h0003);
    @(negedge clk);
    chk("R11 masked sources", 32'(irq), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule